// File: doc/BRIEF.md
# Input Capture Period Meter

This block measures the period of an external digital signal in ticks of a free-running counter. The signal passes through a two-stage synchroniser, and its transitions are qualified by a selectable polarity: rising, falling or both. When a qualified transition arrives, the current counter value is latched into a capture register. The block also subtracts the previous capture from the new one and reports the interval as a period. The subtraction handles counter wrap-around.

A two-bit capture prescaler can thin the qualified transitions, so that a capture happens on every first, second, fourth or eighth one. In counter-reset mode, every qualified transition clears the shared counter. The capture register then holds the interval directly, and the prescaler is bypassed. A capture flag and an overcapture flag report activity to the surrounding logic. While the channel is not configured as an input, software may load the capture register.

Top module: `icap_period_meter`

## Requirements
- R1: `sig_in` passes through two flip-flops before edge detection. A level change that is set up before clock edge k produces a capture on clock edge k+2, and the value latched is the counter value held between edges k+1 and k+2.
- R2: A capture copies the counter value of the cycle in which the qualified transition is seen into `cap_val`.
- R3: The encoding of `edge_sel` is: 2'b01 for rising only, 2'b10 for falling only, 2'b11 for both, and 2'b00 for none. With 2'b00, no capture occurs.
- R4: In free-running mode, when a new capture is not smaller than the previous one, `period` becomes new minus old.
- R5: When a new capture is smaller than the previous one, `period` becomes (2^CNT_W-1 - old) + new.
- R6: When `reset_mode` is 1, each qualified transition captures and then clears the counter to 0. `period` equals the capture, which is the interval in cycles minus one. `psc_sel` has no effect in this mode.
- R7: In free-running mode, the encoding of `psc_sel` is: 0 captures on every qualified transition, 1 on every 2nd, 2 on every 4th, and 3 on every 8th. The prescaler count restarts while `mode_in` is 0.
- R8: Each capture sets `cap_flag`. A `flag_clr` pulse clears it unless a capture occurs in the same cycle.
- R9: `ovr_flag` is set when a capture occurs while `cap_flag` is already 1 and `flag_clr` is low. `flag_clr` clears it.
- R10: `mode_in` selects the channel direction, where any nonzero value means input. While `mode_in` is nonzero, `cap_val` changes only by capture, and `wr_en` is ignored. While `mode_in` is 0, no capture occurs, and `wr_en` loads `wr_data` into `cap_val`.
- R11: The counter advances by one per cycle while `cnt_en` is 1, wraps from 2^CNT_W-1 to 0, and holds while `cnt_en` is 0.
- R12: In free-running mode, `period_valid` rises at the second capture after input mode is entered. Both `period_valid` and the capture history clear while `mode_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| sig_in | input | 1 | Asynchronous signal under measurement |
| edge_sel | input | 2 | Polarity select (R3) |
| psc_sel | input | 2 | Capture prescaler select (R7) |
| reset_mode | input | 1 | Clear the counter on each qualified transition |
| mode_in | input | 2 | Channel direction, where nonzero means input |
| wr_en | input | 1 | Load `cap_val` from `wr_data` while in output direction |
| wr_data | input | CNT_W | Data for software load |
| flag_clr | input | 1 | Clear both flags |
| cnt_val | output | CNT_W | Current counter value |
| cap_val | output | CNT_W | Capture register |
| period | output | CNT_W | Last measured period in ticks |
| period_valid | output | 1 | `period` holds a measured value |
| cap_flag | output | 1 | Capture occurred |
| ovr_flag | output | 1 | Capture occurred while `cap_flag` was still set |

## Verification
The bench drives square waves of several half-periods with rising, falling and both-edge polarity. The both-edge result must be half the single-edge result, and the single-edge polarities must be told apart by the phase of the capture. An 8-bit counter, with the prescaler dividing by eight, forces wrapped and unwrapped capture pairs. Together these separate the plain difference from the wrap formula, including its off-by-one. The bench then runs the same waveform in counter-reset mode with every prescaler setting, to show the prescaler is ignored there. Further stimulus covers polarity none, back-to-back captures for overcapture, software loads in both directions, and a stalled counter.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Interval between two captures on a counter whose top value is maxv.
  function automatic logic [31:0] wrap_gap(input logic [31:0] older,
                                           input logic [31:0] newer,
                                           input logic [31:0] maxv);
    if (newer >= older) return newer - older;
    else                return (maxv - older) + newer;
  endfunction

  // Number of qualified transitions per capture for a prescaler code.
  function automatic logic [3:0] psc_ratio(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/icap_edge_sync.sv
module icap_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_seen,
  output logic fall_seen
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[1:0], async_in};
  end

  // pipe_q[1] is the synchronised level, pipe_q[2] its previous value
  assign rise_seen =  pipe_q[1] & ~pipe_q[2];
  assign fall_seen = ~pipe_q[1] &  pipe_q[2];
endmodule

// File: rtl/icap_presc.sv
module icap_presc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       advance,
  input  logic [1:0] ratio_sel,
  output logic       fire
);
  import icap_pkg::*;

  logic [2:0] seen_q;
  logic [3:0] ratio;
  logic       last_one;

  assign ratio    = psc_ratio(ratio_sel);
  assign last_one = ({1'b0, seen_q} == ratio - 4'd1);
  assign fire     = advance & last_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (restart) seen_q <= '0;
    else if (advance) seen_q <= last_one ? 3'd0 : seen_q + 3'd1;
  end
endmodule

// File: rtl/icap_timebase.sv
module icap_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         zero,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (zero) count <= '0;
    else if (run)  count <= count + 1'b1;
  end
endmodule

// File: rtl/icap_period_meter.sv
module icap_period_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             sig_in,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       psc_sel,
  input  logic             reset_mode,
  input  logic [1:0]       mode_in,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] cap_val,
  output logic [CNT_W-1:0] period,
  output logic             period_valid,
  output logic             cap_flag,
  output logic             ovr_flag
);
  import icap_pkg::*;

  localparam logic [31:0] TOP_VAL = 32'((64'd1 << CNT_W) - 64'd1);

  // named internal events, also watched by the checker
  logic rise_seen, fall_seen, qual_edge, in_dir, presc_fire, cap_ev, cnt_zero;
  logic have_prev;

  edge_mode_e pol;
  assign pol       = edge_mode_e'(edge_sel);
  assign in_dir    = (mode_in != 2'b00);
  assign qual_edge = (rise_seen & (pol == EDGE_RISE || pol == EDGE_BOTH)) |
                     (fall_seen & (pol == EDGE_FALL || pol == EDGE_BOTH));
  assign cap_ev    = in_dir & (reset_mode ? qual_edge : presc_fire);
  assign cnt_zero  = cap_ev & reset_mode;

  icap_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in),
    .rise_seen(rise_seen), .fall_seen(fall_seen)
  );

  icap_presc u_presc (
    .clk(clk), .rst_n(rst_n),
    .restart(~in_dir),
    .advance(in_dir & ~reset_mode & qual_edge),
    .ratio_sel(psc_sel),
    .fire(presc_fire)
  );

  icap_timebase #(.W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(cnt_en), .zero(cnt_zero), .count(cnt_val)
  );

  // capture register, software-loadable only in output direction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cap_val <= '0;
    else if (cap_ev)           cap_val <= cnt_val;
    else if (!in_dir && wr_en) cap_val <= wr_data;
  end

  // period differencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period       <= '0;
      period_valid <= 1'b0;
      have_prev    <= 1'b0;
    end else if (!in_dir) begin
      period_valid <= 1'b0;
      have_prev    <= 1'b0;
    end else if (cap_ev) begin
      have_prev <= 1'b1;
      if (reset_mode) begin
        period       <= cnt_val;
        period_valid <= 1'b1;
      end else if (have_prev) begin
        period       <= CNT_W'(wrap_gap(32'(cap_val), 32'(cnt_val), TOP_VAL));
        period_valid <= 1'b1;
      end
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (cap_ev)        cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
      if (cap_ev && cap_flag && !flag_clr) ovr_flag <= 1'b1;
      else if (flag_clr)                   ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_period_meter_chk.sv
module icap_period_meter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_ev,
  input logic         reset_mode,
  input logic [1:0]   mode_in,
  input logic         flag_clr,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cap_val,
  input logic         cap_flag,
  input logic         ovr_flag
);
  p_capture_copies_counter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_val == $past(cnt_val));

  p_counter_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev && reset_mode |=> cnt_val == '0);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_flag);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !cap_ev |=> !cap_flag && !ovr_flag);

  p_overcapture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev && cap_flag && !flag_clr |=> ovr_flag);

  p_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in != 2'b00) && !cap_ev |=> $stable(cap_val));
endmodule

bind icap_period_meter icap_period_meter_chk #(.W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_ev(cap_ev), .reset_mode(reset_mode),
  .mode_in(mode_in), .flag_clr(flag_clr), .cnt_val(cnt_val),
  .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
);

// File: tb/icap_period_meter_tb_top.sv
module icap_period_meter_tb_top;
  localparam int W = 8;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b1, sig_in = 1'b0, reset_mode = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] edge_sel = 2'b01, psc_sel = 2'b00, mode_in = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_val, cap_val, period;
  logic period_valid, cap_flag, ovr_flag;

  int checks = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  icap_period_meter #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sig_in(sig_in),
    .edge_sel(edge_sel), .psc_sel(psc_sel), .reset_mode(reset_mode),
    .mode_in(mode_in), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .cnt_val(cnt_val), .cap_val(cap_val), .period(period),
    .period_valid(period_valid), .cap_flag(cap_flag), .ovr_flag(ovr_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // square wave source
  bit gen_on = 0;
  int half = 10, ph = 0;
  always @(negedge clk) if (gen_on) begin
    if (ph >= half - 1) begin sig_in <= ~sig_in; ph <= 0; end
    else ph <= ph + 1;
  end

  // behavioural reference model
  int m_hist[$];
  int m_cnt, m_cap, m_per, m_pv, m_hp, m_cf, m_of, m_pc, m_evs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '{0, 0, 0};
      m_cnt = 0; m_cap = 0; m_per = 0; m_pv = 0; m_hp = 0;
      m_cf = 0; m_of = 0; m_pc = 0; m_evs = 0;
    end else begin
      int lvl, prv, q, ev, oldcf;
      bit inm;
      lvl = m_hist[1]; prv = m_hist[2];
      q = ((lvl == 1 && prv == 0 && edge_sel[0]) || (lvl == 0 && prv == 1 && edge_sel[1])) ? 1 : 0;
      inm = (mode_in != 0);
      ev = 0;
      if (!inm) m_pc = 0;
      else if (q == 1) begin
        if (reset_mode) ev = 1;
        else begin
          m_pc++;
          if (m_pc >= (1 << psc_sel)) begin ev = 1; m_pc = 0; end
        end
      end
      oldcf = m_cf;
      if (flag_clr) begin m_cf = 0; m_of = 0; end
      if (ev == 1) begin m_cf = 1; if (oldcf == 1 && !flag_clr) m_of = 1; end
      if (!inm) begin m_pv = 0; m_hp = 0; end
      else if (ev == 1) begin
        if (reset_mode) begin m_per = m_cnt; m_pv = 1; end
        else if (m_hp == 1) begin
          m_per = (m_cnt >= m_cap) ? m_cnt - m_cap : (TOPV - m_cap) + m_cnt;
          m_pv = 1;
        end
        m_hp = 1;
      end
      if (ev == 1) m_cap = m_cnt;
      else if (!inm && wr_en) m_cap = int'(wr_data);
      if (ev == 1 && reset_mode) m_cnt = 0;
      else if (cnt_en) m_cnt = (m_cnt + 1) % (TOPV + 1);
      m_evs += ev;
      m_hist.push_front(int'(sig_in));
      void'(m_hist.pop_back());
    end
  end

  // compare every cycle
  always @(negedge clk) if (rst_n && !done) begin
    chk("R11 cnt_val", int'(cnt_val), m_cnt);
    chk("R2 cap_val", int'(cap_val), m_cap);
    chk("R4 period", int'(period), m_per);
    chk("R12 period_valid", int'(period_valid), m_pv);
    chk("R8 cap_flag", int'(cap_flag), m_cf);
    chk("R9 ovr_flag", int'(ovr_flag), m_of);
  end

  task automatic wait_caps(input int n);
    int tgt;
    tgt = m_evs + n;
    while (m_evs < tgt) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk); mode_in = 2'b00; repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    int prev, c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset cnt", int'(cnt_val), 1);
    chk("R2 reset cap", int'(cap_val), 0);
    chk("R8 reset flag", int'(cap_flag), 0);

    // R1/R4 rising, period 20
    gen_on = 1; mode_in = 2'b01; edge_sel = 2'b01;
    wait_caps(4);
    chk("R4 rising period", int'(period), 20 - ((cap_val < 20) ? 1 : 0));
    chk("R12 valid", int'(period_valid), 1);
    // R3 falling and both
    go_idle(); edge_sel = 2'b10; mode_in = 2'b10; wait_caps(3);
    chk("R3 falling pair", int'(period_valid), 1);
    go_idle(); edge_sel = 2'b11; mode_in = 2'b11; wait_caps(4);
    chk("R3 both edges period", int'(period), 10 - ((cap_val < 10) ? 1 : 0));
    // R3 none
    edge_sel = 2'b00; @(negedge clk); c0 = m_evs; prev = int'(cap_val);
    repeat (100) @(negedge clk);
    chk("R3 none no capture", int'(cap_val), prev);
    chk("R3 none event count", m_evs, c0);

    // R7 prescaler every 4th, R5 wrap with every 8th (interval 160)
    go_idle(); edge_sel = 2'b01; psc_sel = 2'd2; mode_in = 2'b01; wait_caps(3);
    chk("R7 psc4 period", int'(period), 80 - ((cap_val < 80) ? 1 : 0));
    go_idle(); psc_sel = 2'd3; mode_in = 2'b01; wait_caps(1);
    for (int i = 0; i < 5; i++) begin
      prev = int'(cap_val);
      wait_caps(1);
      chk("R5 wrap aware period", int'(period),
          (int'(cap_val) >= prev) ? 160 : (TOPV - prev) + int'(cap_val));
    end

    // R6 reset mode, prescaler ignored
    for (int p = 0; p < 4; p++) begin
      go_idle(); psc_sel = 2'(p); reset_mode = 1; mode_in = 2'b01;
      wait_caps(3);
      chk("R6 reset capture", int'(cap_val), 19);
      chk("R6 reset period", int'(period), 19);
      chk("R6 counter cleared", int'(cnt_val), 0);
    end
    reset_mode = 0;

    // R8/R9 flags
    go_idle(); psc_sel = 0; mode_in = 2'b01; pulse_clr();
    chk("R8 cleared", int'(cap_flag), 0);
    wait_caps(1);
    chk("R8 set", int'(cap_flag), 1);
    chk("R9 no ovr yet", int'(ovr_flag), 0);
    wait_caps(1);
    chk("R9 overcapture", int'(ovr_flag), 1);
    pulse_clr();
    chk("R9 ovr cleared", int'(ovr_flag), 0);

    // R10 software load and read-only
    gen_on = 0; go_idle();
    wr_data = 8'hA5; wr_en = 1; @(negedge clk); wr_en = 0;
    chk("R10 load in output dir", int'(cap_val), 8'hA5);
    chk("R12 valid clear", int'(period_valid), 0);
    mode_in = 2'b01; edge_sel = 2'b00; @(negedge clk);
    wr_data = 8'h3C; wr_en = 1; @(negedge clk); wr_en = 0; @(negedge clk);
    chk("R10 write ignored", int'(cap_val), 8'hA5);

    // R11 counter hold
    cnt_en = 0; @(negedge clk); prev = int'(cnt_val);
    repeat (5) @(negedge clk);
    chk("R11 hold", int'(cnt_val), prev);
    cnt_en = 1; @(negedge clk);
    chk("R11 resume", int'(cnt_val), (prev + 1) % (TOPV + 1));

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule